// File: doc/BRIEF.md
# Passcode-Gated Register Write Lock

This block sits between a 32-bit memory-mapped request channel and a peripheral's register file and decides, for every request, whether it may go on. It holds a single lock flag, placed at offset 0 with a 16-bit key field. The flag comes out of reset set. A full-word write of the unlock key to offset 0 clears it. Any other value written there sets it again. Offset 0 is never gated by the flag itself.

While the flag is set, word writes to every other offset are swallowed. They are acknowledged, but they never reach the register file, and a one-cycle `denied_wr` pulse reports the offset that was refused. Reads always go through to the register file. A request that is not an aligned access is rejected with an error response and is not forwarded. A write whose byte strobes are not all set is also rejected this way.

The request channel `s_*` and the register-file channel `m_*` are valid/ready. A request that is forwarded holds `s_ready` equal to `m_ready`, so the register file can push back. A request that the block handles itself (a lock write, a dropped write or a rejected request) is taken at once with `s_ready` high. Once accepted, a request must not change. Each accepted request gets exactly one response beat.

Top module: `wlk_frontend`

## Requirements
- R1: After reset `locked` is 1, and `resp_valid` and `denied_wr` are 0.
- R2: An accepted full-word write to offset 0 whose low 16 data bits equal 0xDF0D makes `locked` 0 from the next cycle. Data bits 31:16 are ignored.
- R3: An accepted full-word write to offset 0 with any other low 16 bits makes `locked` 1 from the next cycle.
- R4: Full-word writes to offset 0 are accepted whatever the lock state, with `s_ready` high. They never raise `m_valid`.
- R5: While `locked` is 1, a full-word write to a nonzero offset is handled as follows:
  - `m_valid` stays low and `s_ready` is high, even when `m_ready` is low.
  - The response carries `resp_err` 0.
  - In the cycle after acceptance, `denied_wr` is 1 for one cycle and `denied_addr` holds that offset.
  - The register file keeps its old value.
- R6: While `locked` is 0, a full-word write to a nonzero offset is forwarded. `m_valid` equals `s_valid`, `m_addr`, `m_wdata` and `m_write` copy the request, and `s_ready` equals `m_ready`.
- R7: Aligned reads (`s_write` 0) are forwarded as in R6 whatever the lock state, offset 0 included.
- R8: A request is rejected when `s_addr[1:0]` is not 0, or when it is a write with `s_strb` not equal to 4'hF. A rejected request has these effects:
  - It is accepted at once and never raises `m_valid`.
  - It gets `resp_err` 1.
  - It leaves `locked` unchanged and raises no `denied_wr`.
- R9: `resp_valid` is 1 in the cycle after each accepted request, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request valid |
| s_ready | output | 1 | Request accepted this cycle when high with s_valid |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 8 | Byte offset of the request |
| s_wdata | input | 32 | Write data, little-endian |
| s_strb | input | 4 | Byte strobes of a write |
| m_valid | output | 1 | Forwarded request valid to the register file |
| m_ready | input | 1 | Register file accepts the forwarded request |
| m_write | output | 1 | Forwarded direction |
| m_addr | output | 8 | Forwarded byte offset |
| m_wdata | output | 32 | Forwarded write data |
| resp_valid | output | 1 | One response beat per accepted request |
| resp_err | output | 1 | Response is an error (rejected request) |
| locked | output | 1 | Current lock flag |
| denied_wr | output | 1 | One-cycle pulse for a dropped write |
| denied_addr | output | 8 | Offset of the dropped write, valid with denied_wr |

## Verification
The forwarding decision (`m_valid`, `s_ready` and the copied fields) follows the inputs in the same cycle. The bench samples it 2 ns after driving the request at the falling edge, well before the next rising edge. `locked`, `resp_valid`, `resp_err`, `denied_wr` and `denied_addr` each pass through one register. They are sampled 2 ns after the rising edge that accepted the request, and the bench removes or replaces the request only at the following falling edge. Register-file contents are read from the bench's own array model after the writing edge. This shows that a dropped write left its target untouched.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D;

  typedef enum logic [1:0] {
    ACT_FWD    = 2'd0,
    ACT_LOCKWR = 2'd1,
    ACT_DROP   = 2'd2,
    ACT_REJECT = 2'd3
  } act_e;
endpackage

// File: rtl/wlk_classify.sv
module wlk_classify
  import wlk_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            locked,
  input  logic            s_valid,
  input  logic            s_write,
  input  logic [AW-1:0]   s_addr,
  input  logic [DW/8-1:0] s_strb,
  input  logic            m_ready,
  output logic            s_ready,
  output logic            m_valid,
  output act_e            act
);
  localparam int unsigned SW = DW / 8;
  localparam int unsigned LSB = $clog2(SW);

  logic misalign, partial, at_lock;

  always_comb begin
    misalign = |s_addr[LSB-1:0];
    partial  = s_write && (s_strb != {SW{1'b1}});
    at_lock  = (s_addr == '0);
    if (misalign || partial)        act = ACT_REJECT;
    else if (!s_write)              act = ACT_FWD;
    else if (at_lock)               act = ACT_LOCKWR;
    else if (locked)                act = ACT_DROP;
    else                            act = ACT_FWD;
  end

  assign m_valid = s_valid && (act == ACT_FWD);
  assign s_ready = (act == ACT_FWD) ? m_ready : 1'b1;

  // R5: a write never reaches the register file while the lock is set
  p_no_locked_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && s_write) |-> (!locked || s_addr == '0));

  // R8: nothing misaligned or partial is forwarded
  p_reject_not_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (s_addr[LSB-1:0] == '0) && (!s_write || s_strb == {SW{1'b1}}));
endmodule

// File: rtl/wlk_lock_reg.sv
module wlk_lock_reg
  import wlk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] key,
  output logic             locked_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     locked_o <= 1'b1;
    else if (wr_en) locked_o <= (key != UNLOCK_KEY);
  end

  // R2: the exact key clears the flag on the next cycle
  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == UNLOCK_KEY) |=> !locked_o);

  // R3: any other key sets it
  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key != UNLOCK_KEY) |=> locked_o);

  // R8: without a lock write the flag holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(locked_o));
endmodule

// File: rtl/wlk_resp.sv
module wlk_resp
  import wlk_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  act_e          act,
  input  logic [AW-1:0] addr,
  output logic          resp_valid,
  output logic          resp_err,
  output logic          denied_wr,
  output logic [AW-1:0] denied_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_err    <= 1'b0;
      denied_wr   <= 1'b0;
      denied_addr <= '0;
    end else begin
      resp_valid <= fire;
      resp_err   <= fire && (act == ACT_REJECT);
      denied_wr  <= fire && (act == ACT_DROP);
      if (fire && act == ACT_DROP) denied_addr <= addr;
    end
  end

  // R9: every accepted request yields one response beat next cycle
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> resp_valid);

  // R5: a denial pulse only follows an accepted request
  p_denied_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    denied_wr |-> ($past(fire) && resp_valid && !resp_err));
endmodule

// File: rtl/wlk_frontend.sv
module wlk_frontend
  import wlk_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic            s_write,
  input  logic [AW-1:0]   s_addr,
  input  logic [DW-1:0]   s_wdata,
  input  logic [DW/8-1:0] s_strb,
  output logic            m_valid,
  input  logic            m_ready,
  output logic            m_write,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  output logic            resp_valid,
  output logic            resp_err,
  output logic            locked,
  output logic            denied_wr,
  output logic [AW-1:0]   denied_addr
);
  act_e act;
  logic fire;

  wlk_classify #(.AW(AW), .DW(DW)) u_cls (
    .clk(clk), .rst_n(rst_n), .locked(locked),
    .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr), .s_strb(s_strb),
    .m_ready(m_ready), .s_ready(s_ready), .m_valid(m_valid), .act(act)
  );

  assign fire    = s_valid && s_ready;
  assign m_write = s_write;
  assign m_addr  = s_addr;
  assign m_wdata = s_wdata;

  wlk_lock_reg u_lock (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fire && act == ACT_LOCKWR),
    .key(s_wdata[KEY_W-1:0]),
    .locked_o(locked)
  );

  wlk_resp #(.AW(AW)) u_resp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .act(act), .addr(s_addr),
    .resp_valid(resp_valid), .resp_err(resp_err),
    .denied_wr(denied_wr), .denied_addr(denied_addr)
  );

  // R1: reset leaves the block locked and silent
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (locked && !resp_valid && !denied_wr));

  // R4: a lock write is taken at once and kept local
  p_lockwr_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && act == ACT_LOCKWR) |-> (s_ready && !m_valid));
endmodule

// File: tb/tb_wlk_frontend.sv
module tb_wlk_frontend;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_write = 0, m_ready = 1;
  logic [7:0] s_addr = 0;
  logic [31:0] s_wdata = 0;
  logic [3:0] s_strb = 0;
  logic s_ready, m_valid, m_write, resp_valid, resp_err, locked, denied_wr;
  logic [7:0] m_addr, denied_addr;
  logic [31:0] m_wdata;
  logic [31:0] rf [64];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wlk_frontend dut (.*);

  always @(posedge clk)
    if (m_valid && m_ready && m_write) rf[m_addr[7:2]] <= m_wdata;

  typedef struct packed {
    logic w; logic [7:0] a; logic [31:0] d; logic [3:0] st;
    logic fwd; logic err; logic den; logic lk;
  } vec_t;

  localparam vec_t VEC [14] = '{
    {1'b1, 8'h04, 32'h0000_0011, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 drop
    {1'b0, 8'h04, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 read while locked
    {1'b0, 8'h00, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 read offset 0
    {1'b1, 8'h00, 32'h0000_DF0D, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 unlock
    {1'b1, 8'h04, 32'h0000_00AA, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 forward
    {1'b1, 8'h08, 32'h0000_0055, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 partial
    {1'b1, 8'h06, 32'h0000_0055, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 misaligned
    {1'b1, 8'h00, 32'hFFFF_DF0D, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 upper ignored
    {1'b1, 8'h00, 32'h0000_DF0C, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 near key
    {1'b1, 8'h0C, 32'h0000_0077, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 drop
    {1'b1, 8'h00, 32'h0000_DF0D, 4'h3, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 partial key
    {1'b0, 8'h02, 32'h0,         4'h0, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 misaligned read
    {1'b1, 8'h00, 32'h1234_DF0D, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 key while locked
    {1'b1, 8'h00, 32'h0000_0000, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1}  // R3 relock
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic w, logic [7:0] a, logic [31:0] d, logic [3:0] st);
    @(negedge clk);
    s_valid = 1; s_write = w; s_addr = a; s_wdata = d; s_strb = st;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) rf[i] = 32'h0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 locked", {31'b0, locked}, 32'd1);
    chk("R1 resp_valid", {31'b0, resp_valid}, 32'd0);
    chk("R1 denied_wr", {31'b0, denied_wr}, 32'd0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < 14; i++) begin
      drive(VEC[i].w, VEC[i].a, VEC[i].d, VEC[i].st);
      chk($sformatf("R6 m_valid v%0d", i), {31'b0, m_valid}, {31'b0, VEC[i].fwd});
      chk($sformatf("R4 s_ready v%0d", i), {31'b0, s_ready}, 32'd1);
      if (VEC[i].fwd) begin
        chk($sformatf("R7 m_addr v%0d", i), {24'b0, m_addr}, {24'b0, VEC[i].a});
        chk($sformatf("R6 m_write v%0d", i), {31'b0, m_write}, {31'b0, VEC[i].w});
      end
      @(posedge clk); #2;
      chk($sformatf("R9 resp_valid v%0d", i), {31'b0, resp_valid}, 32'd1);
      chk($sformatf("R8 resp_err v%0d", i), {31'b0, resp_err}, {31'b0, VEC[i].err});
      chk($sformatf("R5 denied_wr v%0d", i), {31'b0, denied_wr}, {31'b0, VEC[i].den});
      if (VEC[i].den)
        chk($sformatf("R5 denied_addr v%0d", i), {24'b0, denied_addr}, {24'b0, VEC[i].a});
      chk($sformatf("R2 R3 locked v%0d", i), {31'b0, locked}, {31'b0, VEC[i].lk});
    end
    @(negedge clk) s_valid = 0;
    @(posedge clk); #2;
    chk("R9 no resp when idle", {31'b0, resp_valid}, 32'd0);
    chk("R5 dropped write left rf", rf[3], 32'h0);
    chk("R6 forwarded write stored", rf[1], 32'h0000_00AA);
    chk("R8 partial write not stored", rf[2], 32'h0);

    // R5: locked drop is accepted even under back-pressure
    m_ready = 0;
    drive(1'b1, 8'h10, 32'hCAFE, 4'hF);
    chk("R5 s_ready under backpressure", {31'b0, s_ready}, 32'd1);
    chk("R5 m_valid low", {31'b0, m_valid}, 32'd0);
    @(posedge clk); #2;
    chk("R5 denied under backpressure", {31'b0, denied_wr}, 32'd1);

    // R4: unlock while back-pressured
    drive(1'b1, 8'h00, 32'hDF0D, 4'hF);
    @(posedge clk); #2;
    chk("R4 unlock under backpressure", {31'b0, locked}, 32'd0);
    chk("R5 pulse is one cycle", {31'b0, denied_wr}, 32'd0);

    // R6: forwarded write stalls until m_ready
    drive(1'b1, 8'h10, 32'hBEEF, 4'hF);
    chk("R6 m_valid stalled", {31'b0, m_valid}, 32'd1);
    chk("R6 s_ready follows m_ready", {31'b0, s_ready}, 32'd0);
    chk("R6 m_wdata", m_wdata, 32'hBEEF);
    @(posedge clk); #2;
    chk("R9 no resp while stalled", {31'b0, resp_valid}, 32'd0);
    @(negedge clk) m_ready = 1; #2;
    chk("R6 s_ready released", {31'b0, s_ready}, 32'd1);
    @(posedge clk); #2;
    chk("R9 resp after release", {31'b0, resp_valid}, 32'd1);
    chk("R6 stored after release", rf[4], 32'hBEEF);
    @(negedge clk) s_valid = 0;
    @(posedge clk); #2;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule